// File: doc/BRIEF.md
# 128-bit Control and Status Register Access Unit

This block serves read/modify/write requests to the control and status registers of a hart whose machine width is 128 bits. Each request supplies a 12-bit register address, a 128-bit new value, a 128-bit write mask, the hart's current privilege, its virtualisation state, and a debugger flag. The unit decides whether the access is legal, returns the register's previous contents, and stores the masked merge `(old & ~mask) | (new & mask)` when the mask is nonzero. A global enable input can switch off all register access.

A fixed group of machine identification and trap registers is served natively at 128 bits. Some return constant contents, and writes to that group are accepted and dropped. A second group is held in 64-bit storage and reached through the low halves of value and mask, with results zero-extended. Access rights come entirely from the address: the top two bits mark read-only registers and the next two give the minimum privilege. When the hypervisor option is built in, an S-mode hart with virtualisation off is treated as one level higher.

The request side takes a transfer on any cycle where valid and ready are both high. The response data and exception flag are registered and appear one cycle later.

Top module: `csr128_unit`

## Requirements
- R1: `req_ready` is low during reset and high afterwards. `resp_valid` is high in exactly the cycle after each cycle in which `req_valid` and `req_ready` are both high, and low otherwise.
- R2: Addresses with bits [11:10] equal to 2'b11 are read-only. A request to one with any nonzero mask bit, including only upper-half bits, raises `resp_illegal`. The same request with an all-zero mask is legal.
- R3: Privilege is encoded U=2'b00, S=2'b01, M=2'b11, and address bits [9:8] give the minimum level. A request whose effective privilege is below that level raises `resp_illegal`, unless `req_debug` is high.
- R4: With HAS_HYP=1, a request in S-mode with `req_virt` low has effective privilege 2. It can therefore reach level-2 registers but still not level-3 ones. With `req_virt` high it stays at 1.
- R5: When `csr_enable` is low, every request raises `resp_illegal`.
- R6: A legal-rights request to an address outside the implemented set raises `resp_illegal`.
- R7: Reading misa (0x301) returns MISA_EXT in bits [63:0], 2'b11 in bits [127:126], and zeros elsewhere.
- R8: Reading mhartid (0xF14) returns HART_ID zero-extended to 128 bits.
- R9: mvendorid 0xF11, marchid 0xF12, mimpid 0xF13, mstatus 0x300, mtvec 0x305, mscratch 0x340, mepc 0x341 and satp 0x180 read as zero. A write to any of them raises no exception and leaves a later read at zero.
- R10: sscratch 0x140, sepc 0x141, mcause 0x342, mtval 0x343 and hscratch 0x640 are 64-bit registers. A read returns the old value zero-extended. A write stores `(old & ~mask[63:0]) | (new[63:0] & mask[63:0])`, and a low-half mask of zero leaves the register unchanged.
- R11: When a request raises `resp_illegal`, `resp_rdata` is zero and no register changes.
- R12: After reset, `resp_valid`, `resp_illegal` and `resp_rdata` are zero and all 64-bit registers hold zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_enable | input | 1 | Global register-access enable |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request |
| req_addr | input | 12 | Register address |
| req_wdata | input | 128 | New value |
| req_wmask | input | 128 | Bits to be written |
| req_priv | input | 2 | Current privilege (U=00, S=01, M=11) |
| req_virt | input | 1 | Virtualisation active |
| req_debug | input | 1 | Debugger access, bypasses privilege check |
| resp_valid | output | 1 | Response present |
| resp_rdata | output | 128 | Previous register contents |
| resp_illegal | output | 1 | Illegal-instruction exception |

## Verification
A wrong bit in one of the 64-bit registers stays hidden until the next read of that address. At that read it shows on `resp_rdata` one cycle after acceptance, so the bench follows every write with a read. A stuck or mis-decoded permission shows on `resp_illegal` in the response cycle of the very request it affects. An exception that still lets a write through shows up only on the following read, as a changed value. A broken handshake register shows as a missing or extra `resp_valid`, which is compared on every clock.

// File: rtl/csr128_pkg.sv
package csr128_pkg;

  localparam int XLEN      = 128;
  localparam int LEG_W     = 64;
  localparam int LEG_N     = 5;
  localparam int LEG_IDX_W = $clog2(LEG_N);

  typedef enum logic [1:0] {
    VAL_ZERO = 2'd0,
    VAL_MISA = 2'd1,
    VAL_HART = 2'd2
  } fixed_kind_e;

  typedef struct packed {
    logic                 fixed_hit;
    fixed_kind_e          kind;
    logic                 leg_hit;
    logic [LEG_IDX_W-1:0] leg_idx;
  } csr_sel_t;

  localparam logic [1:0] RV128_MXL = 2'b11;

endpackage

// File: rtl/csr128_decode.sv
module csr128_decode
  import csr128_pkg::*;
(
  input  logic [11:0] addr,
  output csr_sel_t    sel
);

  always_comb begin
    sel = '0;
    unique case (addr)
      12'hF11, 12'hF12, 12'hF13,
      12'h300, 12'h305, 12'h340,
      12'h341, 12'h180: begin
        sel.fixed_hit = 1'b1;
        sel.kind      = VAL_ZERO;
      end
      12'h301: begin
        sel.fixed_hit = 1'b1;
        sel.kind      = VAL_MISA;
      end
      12'hF14: begin
        sel.fixed_hit = 1'b1;
        sel.kind      = VAL_HART;
      end
      12'h140: begin sel.leg_hit = 1'b1; sel.leg_idx = LEG_IDX_W'(0); end
      12'h141: begin sel.leg_hit = 1'b1; sel.leg_idx = LEG_IDX_W'(1); end
      12'h342: begin sel.leg_hit = 1'b1; sel.leg_idx = LEG_IDX_W'(2); end
      12'h343: begin sel.leg_hit = 1'b1; sel.leg_idx = LEG_IDX_W'(3); end
      12'h640: begin sel.leg_hit = 1'b1; sel.leg_idx = LEG_IDX_W'(4); end
      default: sel = '0;
    endcase
  end

endmodule

// File: rtl/csr128_access_check.sv
module csr128_access_check #(
  parameter bit HAS_HYP = 1'b1
) (
  input  logic [11:0] addr,
  input  logic        mask_nz,
  input  logic [1:0]  priv,
  input  logic        virt,
  input  logic        debug,
  input  logic        enable,
  input  logic        exists,
  output logic        illegal
);

  logic [2:0] eff_priv;
  logic [2:0] need_priv;
  logic       read_only;

  assign read_only = (addr[11:10] == 2'b11);
  assign need_priv = {1'b0, addr[9:8]};

  generate
    if (HAS_HYP) begin : g_hyp
      logic raise;
      assign raise    = (priv == 2'b01) && !virt;
      assign eff_priv = {1'b0, priv} + {2'b00, raise};
    end else begin : g_nohyp
      logic unused_virt;
      assign unused_virt = virt;
      assign eff_priv    = {1'b0, priv};
    end
  endgenerate

  // Ordered checks: rights, then global enable, then existence.
  always_comb begin
    if ((mask_nz && read_only) || (!debug && (eff_priv < need_priv)))
      illegal = 1'b1;
    else if (!enable)
      illegal = 1'b1;
    else if (!exists)
      illegal = 1'b1;
    else
      illegal = 1'b0;
  end

endmodule

// File: rtl/csr128_legacy_file.sv
module csr128_legacy_file #(
  parameter int N     = 5,
  parameter int W     = 64,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [W-1:0]     rd_data,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [W-1:0]     wr_data
);

  logic [W-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) mem[i] <= '0;
    end else if (we && (int'(wr_idx) < N)) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign rd_data = (int'(rd_idx) < N) ? mem[rd_idx] : '0;

endmodule

// File: rtl/csr128_unit.sv
module csr128_unit
  import csr128_pkg::*;
#(
  parameter logic [63:0] MISA_EXT = 64'h0000_0000_0014_1185,
  parameter logic [63:0] HART_ID  = 64'h0000_0000_0000_0003,
  parameter bit          HAS_HYP  = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             csr_enable,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [11:0]      req_addr,
  input  logic [XLEN-1:0]  req_wdata,
  input  logic [XLEN-1:0]  req_wmask,
  input  logic [1:0]       req_priv,
  input  logic             req_virt,
  input  logic             req_debug,
  output logic             resp_valid,
  output logic [XLEN-1:0]  resp_rdata,
  output logic             resp_illegal
);

  localparam int PAD_W = XLEN - LEG_W;

  csr_sel_t            sel;
  logic                accept;
  logic                illegal;
  logic [LEG_W-1:0]    leg_old;
  logic [LEG_W-1:0]    leg_new;
  logic                leg_we;
  logic [XLEN-1:0]     old_val;
  logic                unused_hi;

  assign accept    = req_valid && req_ready;
  assign unused_hi = ^req_wdata[XLEN-1:LEG_W];

  csr128_decode u_dec (
    .addr (req_addr),
    .sel  (sel)
  );

  csr128_access_check #(.HAS_HYP(HAS_HYP)) u_chk (
    .addr    (req_addr),
    .mask_nz (|req_wmask),
    .priv    (req_priv),
    .virt    (req_virt),
    .debug   (req_debug),
    .enable  (csr_enable),
    .exists  (sel.fixed_hit || sel.leg_hit),
    .illegal (illegal)
  );

  csr128_legacy_file #(.N(LEG_N), .W(LEG_W)) u_leg (
    .clk     (clk),
    .rst     (rst),
    .rd_idx  (sel.leg_idx),
    .rd_data (leg_old),
    .we      (leg_we),
    .wr_idx  (sel.leg_idx),
    .wr_data (leg_new)
  );

  assign leg_new = (leg_old & ~req_wmask[LEG_W-1:0]) |
                   (req_wdata[LEG_W-1:0] & req_wmask[LEG_W-1:0]);
  assign leg_we  = accept && !illegal && sel.leg_hit && (|req_wmask[LEG_W-1:0]);

  always_comb begin
    old_val = '0;
    if (sel.fixed_hit) begin
      unique case (sel.kind)
        VAL_MISA: old_val = {RV128_MXL, {(PAD_W-2){1'b0}}, MISA_EXT};
        VAL_HART: old_val = {{PAD_W{1'b0}}, HART_ID};
        default:  old_val = '0;
      endcase
    end else if (sel.leg_hit) begin
      old_val = {{PAD_W{1'b0}}, leg_old};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_ready    <= 1'b0;
      resp_valid   <= 1'b0;
      resp_rdata   <= '0;
      resp_illegal <= 1'b0;
    end else begin
      req_ready  <= 1'b1;
      resp_valid <= accept;
      if (accept) begin
        resp_illegal <= illegal;
        resp_rdata   <= illegal ? '0 : old_val;
      end
    end
  end

endmodule

// File: rtl/csr128_unit_chk.sv
module csr128_unit_chk (
  input logic         clk,
  input logic         rst,
  input logic         csr_enable,
  input logic         req_valid,
  input logic         req_ready,
  input logic [11:0]  req_addr,
  input logic [127:0] req_wmask,
  input logic [1:0]   req_priv,
  input logic         req_debug,
  input logic         resp_valid,
  input logic [127:0] resp_rdata,
  input logic         resp_illegal
);

  AST_RESP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> resp_valid); // R1

  AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready) |=> !resp_valid); // R1

  AST_RO_WRITE_TRAPS: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_addr[11:10] == 2'b11 && |req_wmask)
      |=> resp_illegal); // R2

  AST_USER_PRIV_TRAP: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_priv == 2'b00 && !req_debug && req_addr[9:8] != 2'b00)
      |=> resp_illegal); // R3

  AST_DISABLED_TRAPS: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !csr_enable) |=> resp_illegal); // R5

  AST_ILLEGAL_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_illegal) |-> (resp_rdata == '0)); // R11

  AST_MISA_TOP_BITS: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && csr_enable && req_addr == 12'h301 &&
     req_priv == 2'b11 && req_wmask == '0)
      |=> (resp_rdata[127:126] == 2'b11 && !resp_illegal)); // R7

endmodule

bind csr128_unit csr128_unit_chk u_unit_chk (.*);

// File: tb/csr128_unit_test.sv
module csr128_unit_test;

  localparam logic [63:0] T_MISA = 64'h0000_0000_0014_1185;
  localparam logic [63:0] T_HART = 64'h0000_0000_0000_0003;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         csr_enable = 1'b1;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [11:0]  req_addr = '0;
  logic [127:0] req_wdata = '0;
  logic [127:0] req_wmask = '0;
  logic [1:0]   req_priv = 2'b11;
  logic         req_virt = 1'b0;
  logic         req_debug = 1'b0;
  logic         resp_valid;
  logic [127:0] resp_rdata;
  logic         resp_illegal;

  int tests = 0;
  int fails = 0;
  logic exp_valid = 1'b0;
  logic [63:0] model [int];

  always #2 clk = ~clk;

  csr128_unit #(.MISA_EXT(T_MISA), .HART_ID(T_HART), .HAS_HYP(1'b1)) uut (
    .clk(clk), .rst(rst), .csr_enable(csr_enable),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_wmask(req_wmask), .req_priv(req_priv),
    .req_virt(req_virt), .req_debug(req_debug), .resp_valid(resp_valid),
    .resp_rdata(resp_rdata), .resp_illegal(resp_illegal)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Per-clock handshake model (R1)
  always @(posedge clk) exp_valid <= rst ? 1'b0 : (req_valid && !rst);
  always @(negedge clk) if (!rst)
    check(resp_valid == exp_valid, "R1 resp_valid", {127'b0, resp_valid}, {127'b0, exp_valid});

  function automatic int leg_slot(input logic [11:0] a);
    case (a)
      12'h140: return 0;
      12'h141: return 1;
      12'h342: return 2;
      12'h343: return 3;
      12'h640: return 4;
      default: return -1;
    endcase
  endfunction

  task automatic access(input logic [11:0] a, input logic [127:0] wd,
                        input logic [127:0] wm, input logic [1:0] pv,
                        input bit vt, input bit dbg, input bit en, input string req);
    bit ill;
    bit known;
    int eff;
    int slot;
    logic [127:0] rd;
    @(negedge clk);
    req_addr = a; req_wdata = wd; req_wmask = wm; req_priv = pv;
    req_virt = vt; req_debug = dbg; csr_enable = en; req_valid = 1'b1;
    slot = leg_slot(a);
    known = 1'b1;
    rd = '0;
    case (a)
      12'hF11, 12'hF12, 12'hF13, 12'h300, 12'h305, 12'h340, 12'h341, 12'h180: rd = '0;
      12'h301: rd = {2'b11, 62'b0, T_MISA};
      12'hF14: rd = {64'b0, T_HART};
      default: if (slot >= 0) rd = {64'b0, model[slot]}; else known = 1'b0;
    endcase
    eff = int'(pv) + ((pv == 2'b01 && !vt) ? 1 : 0);
    ill = 1'b0;
    if (wm != '0 && a[11:10] == 2'b11) ill = 1'b1;
    if (!dbg && eff < int'(a[9:8])) ill = 1'b1;
    if (!en) ill = 1'b1;
    if (!known) ill = 1'b1;
    if (ill) rd = '0;
    else if (slot >= 0 && wm[63:0] != '0)
      model[slot] = (model[slot] & ~wm[63:0]) | (wd[63:0] & wm[63:0]);
    @(negedge clk);
    req_valid = 1'b0;
    check(resp_valid == 1'b1, {req, " valid"}, {127'b0, resp_valid}, 128'd1);
    check(resp_illegal == ill, {req, " illegal"}, {127'b0, resp_illegal}, {127'b0, ill});
    check(resp_rdata == rd, {req, " rdata"}, resp_rdata, rd);
  endtask

  localparam logic [127:0] ONES = '1;
  localparam logic [127:0] NONE = '0;
  localparam logic [127:0] PAT  = 128'hAAAA_5555_1234_5678_DEAD_BEEF_CAFE_F00D;

  initial begin
    for (int i = 0; i < 5; i++) model[i] = 64'h0;
    repeat (3) @(negedge clk);
    // R12 reset state, R1 ready low in reset
    check(resp_valid == 1'b0, "R12 resp_valid", {127'b0, resp_valid}, '0);
    check(resp_illegal == 1'b0, "R12 resp_illegal", {127'b0, resp_illegal}, '0);
    check(resp_rdata == '0, "R12 resp_rdata", resp_rdata, '0);
    check(req_ready == 1'b0, "R1 ready in reset", {127'b0, req_ready}, '0);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready after reset", {127'b0, req_ready}, 128'd1);

    access(12'h140, PAT, NONE, 2'b11, 0, 0, 1, "R12 sscratch reset");
    access(12'h643 - 12'h003, PAT, NONE, 2'b11, 0, 0, 1, "R12 hscratch reset");
    access(12'h301, PAT, NONE, 2'b11, 0, 0, 1, "R7 misa");
    access(12'hF14, PAT, NONE, 2'b11, 0, 0, 1, "R8 mhartid");
    access(12'hF11, PAT, NONE, 2'b11, 0, 0, 1, "R9 mvendorid");
    access(12'h180, PAT, NONE, 2'b11, 0, 0, 1, "R9 satp");
    access(12'h340, PAT, ONES, 2'b11, 0, 0, 1, "R9 mscratch write");
    access(12'h340, NONE, NONE, 2'b11, 0, 0, 1, "R9 mscratch read");
    access(12'h300, PAT, ONES, 2'b11, 0, 0, 1, "R9 mstatus write");

    access(12'h140, PAT, ONES, 2'b11, 0, 0, 1, "R10 sscratch full write");
    access(12'h140, NONE, NONE, 2'b11, 0, 0, 1, "R10 sscratch read");
    access(12'h140, ONES, 128'h0000_FFFF_0000_FF00, 2'b11, 0, 0, 1, "R10 partial merge");
    access(12'h140, NONE, NONE, 2'b11, 0, 0, 1, "R10 merge read");
    access(12'h140, ONES, {64'hFFFF_FFFF_FFFF_FFFF, 64'h0}, 2'b11, 0, 0, 1, "R10 high-only mask");
    access(12'h342, 128'h8000_0000_0000_000B, ONES, 2'b11, 0, 0, 1, "R10 mcause write");
    access(12'h342, NONE, NONE, 2'b11, 0, 0, 1, "R10 mcause read");

    access(12'hF14, PAT, ONES, 2'b11, 0, 0, 1, "R2 ro write");
    access(12'hF13, PAT, {1'b1, 127'b0}, 2'b11, 0, 0, 1, "R2 ro high mask");
    access(12'hF12, PAT, NONE, 2'b11, 0, 0, 1, "R2 ro read ok");

    access(12'h140, NONE, NONE, 2'b00, 0, 0, 1, "R3 user to S reg");
    access(12'h140, NONE, NONE, 2'b00, 0, 1, 1, "R3 debug bypass");
    access(12'h343, PAT, ONES, 2'b00, 0, 1, 1, "R3 debug write");
    access(12'h343, NONE, NONE, 2'b11, 0, 0, 1, "R3 debug write read");
    access(12'h141, PAT, ONES, 2'b01, 1, 0, 1, "R3 S to S reg");

    access(12'h640, PAT, ONES, 2'b01, 0, 0, 1, "R4 HS write hscratch");
    access(12'h640, NONE, NONE, 2'b01, 0, 0, 1, "R4 HS read hscratch");
    access(12'h640, NONE, NONE, 2'b01, 1, 0, 1, "R4 VS blocked");
    access(12'h300, NONE, NONE, 2'b01, 0, 0, 1, "R4 HS to M reg");

    access(12'h141, ONES, ONES, 2'b11, 0, 0, 0, "R5 disabled write");
    access(12'h141, NONE, NONE, 2'b11, 0, 0, 1, "R11 unchanged after disabled");
    access(12'h7C0, NONE, NONE, 2'b11, 0, 0, 1, "R6 unknown");
    access(12'h5A5, NONE, NONE, 2'b11, 0, 1, 1, "R6 unknown debug");
    access(12'h342, ONES, ONES, 2'b00, 0, 0, 1, "R11 user write mcause");
    access(12'h342, NONE, NONE, 2'b11, 0, 0, 1, "R11 mcause kept");

    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule